// File: doc/BRIEF.md
# Per-Timeslot Loopback Switch

This block sits between the system-side and line-side byte streams of a 32-channel TDM framer. It steers each byte by timeslot. One direction loops the system transmit byte back to system receive (local loop). The other loops the line receive byte back to line transmit (remote loop). Each timeslot chooses these loops on its own, so any set of channels can be looped in either or both directions while the rest pass straight through.

All four streams arrive already aligned. One valid strobe and a 5-bit timeslot index apply to all of them in a given cycle. A simple register port holds one 8-bit control word per timeslot. The two loop flags sit in that word, and the block reads the word for the current timeslot when the timeslot's byte arrives. Both outputs are registered, so the switched bytes appear one clock after their inputs, tagged with the same timeslot index.

Top module: `ts_loop_switch`

## Requirements
- R1: After reset every control word reads 0, `out_vld` is 0 and both data outputs are 0x00.
- R2: A write with `cfg_we` high stores `cfg_wdata` at word `cfg_addr` on the clock edge. From the next cycle, `cfg_rdata` returns all 8 bits of the word selected by `cfg_addr`.
- R3: In a valid cycle for timeslot n, `sys_rx_byte` on the next cycle equals the `sys_tx_byte` input when bit 4 of word n is 1. It equals `line_rx_byte` when that bit is 0.
- R4: In a valid cycle for timeslot n, `line_tx_byte` on the next cycle equals the `line_rx_byte` input when bit 5 of word n is 1. It equals `sys_tx_byte` when that bit is 0.
- R5: With bits 4 and 5 both set, the two directions act independently: line transmit carries line receive data and system receive carries system transmit data.
- R6: Word n affects only timeslot n. Timeslots whose words have zero loop bits pass data straight through, whatever the other words hold.
- R7: A write to word n in the same cycle as a timeslot n byte does not affect that byte. It takes effect from the next occurrence of timeslot n.
- R8: `out_vld` follows `slot_vld` by one cycle. When it is high, `out_slot` equals the timeslot index of the previous cycle.
- R9: Bits other than 4 and 5 are stored and read back but do not affect the data path.
- R10: In a cycle with `slot_vld` low, `out_vld` goes low on the next cycle and both data outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 5 | Control word address (timeslot number) |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word at `cfg_addr` |
| slot_vld | input | 1 | A timeslot byte is present on all streams |
| slot_idx | input | 5 | Timeslot index of the present bytes |
| sys_tx_byte | input | 8 | System-side transmit byte |
| line_rx_byte | input | 8 | Line-side receive byte |
| line_tx_byte | output | 8 | Line-side transmit byte, registered |
| sys_rx_byte | output | 8 | System-side receive byte, registered |
| out_vld | output | 1 | Output bytes valid |
| out_slot | output | 5 | Timeslot index of the output bytes |

## Verification
The bench tests each loop bit alone, both bits together and neither. Swapping the bit positions or the two directions would send bytes to the wrong output. It writes a word in the very cycle its timeslot passes. A design that forwards write data into the lookup would switch that byte early. It sends timeslots next to looped ones to catch decoding that leaks across slots, and it sets the non-loop bits to show they do nothing. Idle cycles check that a design clocking data without the strobe would corrupt the held outputs.

// File: rtl/ts_loop_pkg.sv
// Shared constants and types for the per-timeslot loopback switch.
// Assumes one control word per timeslot and a byte-wide data path.
package ts_loop_pkg;
    localparam int unsigned NUM_SLOTS = 32;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned LLOOP_BIT = 4;  // system tx -> system rx
    localparam int unsigned RLOOP_BIT = 5;  // line rx -> line tx

    typedef struct packed {
        logic rloop;
        logic lloop;
    } loop_sel_t;
endpackage

// File: rtl/ts_ctrl_store.sv
// Per-timeslot control word file. One write port and two combinational
// read ports: a full-word port for the register interface, and a port
// that returns the loop flags for the timeslot now on the streams.
// Assumes NUM_SLOTS equals 2**SLOT_W so every address is a valid word.
module ts_ctrl_store
    import ts_loop_pkg::*;
#(
    parameter int unsigned N_WORDS = NUM_SLOTS,
    parameter int unsigned WORD_W  = BYTE_W,
    parameter int unsigned ADDR_W  = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] sel_addr,
    output loop_sel_t         sel_flags
);
    logic [WORD_W-1:0] words [N_WORDS];

    // One register per timeslot, cleared on reset, loaded on an address match.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                words[g] <= wr_data;
        end
    end

    // Register-port read-back of the addressed word.
    always_comb rd_data = words[rd_addr];

    // Loop flags of the timeslot being switched, taken from the stored value.
    always_comb begin
        sel_flags.lloop = words[sel_addr][LLOOP_BIT];
        sel_flags.rloop = words[sel_addr][RLOOP_BIT];
    end
endmodule

// File: rtl/ts_byte_mux.sv
// Byte selector for one timeslot: picks the line transmit source and the
// system receive source from the two loop flags. Purely combinational.
module ts_byte_mux
    import ts_loop_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  loop_sel_t         flags,
    input  logic [DATA_W-1:0] sys_tx,
    input  logic [DATA_W-1:0] line_rx,
    output logic [DATA_W-1:0] line_tx_nxt,
    output logic [DATA_W-1:0] sys_rx_nxt
);
    // Each direction uses only its own flag, so both may be active at once.
    always_comb begin
        line_tx_nxt = flags.rloop ? line_rx : sys_tx;
        sys_rx_nxt  = flags.lloop ? sys_tx  : line_rx;
    end
endmodule

// File: rtl/ts_out_stage.sv
// Output register for the switched bytes and their timeslot tag.
// The data registers load only on valid cycles and hold otherwise.
module ts_out_stage #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [DATA_W-1:0] in_line_tx,
    input  logic [DATA_W-1:0] in_sys_rx,
    output logic              out_vld,
    output logic [SLOT_W-1:0] out_slot,
    output logic [DATA_W-1:0] out_line_tx,
    output logic [DATA_W-1:0] out_sys_rx
);
    // Valid strobe follows the input strobe every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    // Data and tag load on valid cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_slot    <= '0;
            out_line_tx <= '0;
            out_sys_rx  <= '0;
        end else if (in_vld) begin
            out_slot    <= in_slot;
            out_line_tx <= in_line_tx;
            out_sys_rx  <= in_sys_rx;
        end
    end
endmodule

// File: rtl/ts_loop_switch.sv
// Per-timeslot loopback switch. Looks up the control word of the timeslot
// on the streams, selects the line transmit and system receive bytes, and
// registers them. Assumes all four streams share one timeslot tag.
// Control writes land on the clock edge, so a byte always sees the word
// as it stood before that edge.
module ts_loop_switch
    import ts_loop_pkg::*;
#(
    parameter int unsigned N_SLOTS = NUM_SLOTS,
    parameter int unsigned DATA_W  = BYTE_W,
    parameter int unsigned SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              slot_vld,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [DATA_W-1:0] sys_tx_byte,
    input  logic [DATA_W-1:0] line_rx_byte,
    output logic [DATA_W-1:0] line_tx_byte,
    output logic [DATA_W-1:0] sys_rx_byte,
    output logic              out_vld,
    output logic [SLOT_W-1:0] out_slot
);
    loop_sel_t         cur_flags;
    logic [DATA_W-1:0] line_tx_nxt;
    logic [DATA_W-1:0] sys_rx_nxt;

    ts_ctrl_store #(
        .N_WORDS (N_SLOTS),
        .WORD_W  (DATA_W),
        .ADDR_W  (SLOT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .rd_addr   (cfg_addr),
        .rd_data   (cfg_rdata),
        .sel_addr  (slot_idx),
        .sel_flags (cur_flags)
    );

    ts_byte_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .flags       (cur_flags),
        .sys_tx      (sys_tx_byte),
        .line_rx     (line_rx_byte),
        .line_tx_nxt (line_tx_nxt),
        .sys_rx_nxt  (sys_rx_nxt)
    );

    ts_out_stage #(
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_vld      (slot_vld),
        .in_slot     (slot_idx),
        .in_line_tx  (line_tx_nxt),
        .in_sys_rx   (sys_rx_nxt),
        .out_vld     (out_vld),
        .out_slot    (out_slot),
        .out_line_tx (line_tx_byte),
        .out_sys_rx  (sys_rx_byte)
    );
endmodule

// File: rtl/ts_loop_switch_chk.sv
// Checker for ts_loop_switch. It keeps its own shadow of the control words,
// built from the register port writes, and checks the outputs against it.
module ts_loop_switch_chk
    import ts_loop_pkg::*;
#(
    parameter int unsigned N_SLOTS = NUM_SLOTS,
    parameter int unsigned DATA_W  = BYTE_W,
    parameter int unsigned SLOT_W  = $clog2(N_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SLOT_W-1:0] cfg_addr,
    input logic              cfg_we,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              slot_vld,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [DATA_W-1:0] sys_tx_byte,
    input logic [DATA_W-1:0] line_rx_byte,
    input logic [DATA_W-1:0] line_tx_byte,
    input logic [DATA_W-1:0] sys_rx_byte,
    input logic              out_vld,
    input logic [SLOT_W-1:0] out_slot
);
    logic [DATA_W-1:0] shadow [N_SLOTS];
    logic              exp_rl;
    logic              exp_ll;

    // Shadow copy of the control words, from observed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) shadow[i] <= '0;
        end else if (cfg_we) begin
            shadow[cfg_addr] <= cfg_wdata;
        end
    end

    // Loop flags expected for the timeslot now on the streams.
    always_comb begin
        exp_rl = shadow[slot_idx][RLOOP_BIT];
        exp_ll = shadow[slot_idx][LLOOP_BIT];
    end

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata == shadow[cfg_addr]);

    // R4
    remote_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> line_tx_byte == ($past(exp_rl) ? $past(line_rx_byte) : $past(sys_tx_byte)));

    // R3
    local_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> sys_rx_byte == ($past(exp_ll) ? $past(sys_tx_byte) : $past(line_rx_byte)));

    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> out_vld && (out_slot == $past(slot_idx)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld |=> !out_vld && $stable(line_tx_byte) && $stable(sys_rx_byte));
endmodule

bind ts_loop_switch ts_loop_switch_chk #(
    .N_SLOTS (N_SLOTS),
    .DATA_W  (DATA_W),
    .SLOT_W  (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_addr     (cfg_addr),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .slot_vld     (slot_vld),
    .slot_idx     (slot_idx),
    .sys_tx_byte  (sys_tx_byte),
    .line_rx_byte (line_rx_byte),
    .line_tx_byte (line_tx_byte),
    .sys_rx_byte  (sys_rx_byte),
    .out_vld      (out_vld),
    .out_slot     (out_slot)
);

// File: tb/ts_loop_switch_bench.sv
module ts_loop_switch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       slot_vld = 1'b0;
    logic [4:0] slot_idx = '0;
    logic [7:0] sys_tx_byte = '0;
    logic [7:0] line_rx_byte = '0;
    logic [7:0] line_tx_byte;
    logic [7:0] sys_rx_byte;
    logic       out_vld;
    logic [4:0] out_slot;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    ts_loop_switch u_ts_loop_switch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_addr     (cfg_addr),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .slot_vld     (slot_vld),
        .slot_idx     (slot_idx),
        .sys_tx_byte  (sys_tx_byte),
        .line_rx_byte (line_rx_byte),
        .line_tx_byte (line_tx_byte),
        .sys_rx_byte  (sys_rx_byte),
        .out_vld      (out_vld),
        .out_slot     (out_slot)
    );

    // Vector: {word, slot, sys_tx, line_rx, exp_line_tx, exp_sys_rx}
    localparam int NVEC = 7;
    localparam logic [44:0] VEC [NVEC] = '{
        {8'h00, 5'd3,  8'hA1, 8'h5B, 8'hA1, 8'h5B},  // R3 R4 straight
        {8'h10, 5'd7,  8'hC3, 8'h3C, 8'hC3, 8'hC3},  // R3 local only
        {8'h20, 5'd12, 8'h77, 8'h88, 8'h88, 8'h88},  // R4 remote only
        {8'h30, 5'd31, 8'hE4, 8'h1F, 8'h1F, 8'hE4},  // R5 both
        {8'h0F, 5'd0,  8'h42, 8'h24, 8'h42, 8'h24},  // R9 low bits
        {8'hCF, 5'd20, 8'h99, 8'h66, 8'h99, 8'h66},  // R9 high bits
        {8'h10, 5'd0,  8'h5A, 8'hA5, 8'h5A, 8'h5A}   // R3 rewrite slot 0
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [4:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [4:0] s, input logic [7:0] st, input logic [7:0] lr);
        slot_vld = 1'b1; slot_idx = s; sys_tx_byte = st; line_rx_byte = lr;
        @(negedge clk);
        slot_vld = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_vld", {7'd0, out_vld}, 8'h00);
        check("R1 line_tx", line_tx_byte, 8'h00);
        check("R1 sys_rx", sys_rx_byte, 8'h00);
        for (int a = 0; a < 32; a += 9) begin
            cfg_addr = 5'(a);
            #1;
            check("R1 word", cfg_rdata, 8'h00);
        end

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            write_word(VEC[i][36:32], VEC[i][44:37]);
            check("R2 readback", cfg_rdata, VEC[i][44:37]);
            send(VEC[i][36:32], VEC[i][31:24], VEC[i][23:16]);
            check("R4 line_tx", line_tx_byte, VEC[i][15:8]);
            check("R3 sys_rx", sys_rx_byte, VEC[i][7:0]);
            check("R8 out_vld", {7'd0, out_vld}, 8'h01);
            check("R8 out_slot", {3'd0, out_slot}, {3'd0, VEC[i][36:32]});
        end

        // R6 neighbours of looped slots pass straight through
        send(5'd8, 8'h13, 8'h31);
        check("R6 slot8 line_tx", line_tx_byte, 8'h13);
        check("R6 slot8 sys_rx", sys_rx_byte, 8'h31);
        send(5'd11, 8'hB2, 8'h2B);
        check("R6 slot11 line_tx", line_tx_byte, 8'hB2);
        check("R6 slot11 sys_rx", sys_rx_byte, 8'h2B);

        // R7 write in the same cycle as the slot's byte
        cfg_addr = 5'd9; cfg_wdata = 8'h30; cfg_we = 1'b1;
        slot_vld = 1'b1; slot_idx = 5'd9; sys_tx_byte = 8'h11; line_rx_byte = 8'h22;
        @(negedge clk);
        cfg_we = 1'b0; slot_vld = 1'b0;
        check("R7 old line_tx", line_tx_byte, 8'h11);
        check("R7 old sys_rx", sys_rx_byte, 8'h22);
        send(5'd9, 8'h11, 8'h22);
        check("R7 new line_tx", line_tx_byte, 8'h22);
        check("R7 new sys_rx", sys_rx_byte, 8'h11);

        // R10 idle cycle holds outputs
        slot_vld = 1'b0; slot_idx = 5'd3; sys_tx_byte = 8'hFE; line_rx_byte = 8'hEF;
        @(negedge clk);
        check("R10 out_vld", {7'd0, out_vld}, 8'h00);
        check("R10 line_tx", line_tx_byte, 8'h22);
        check("R10 sys_rx", sys_rx_byte, 8'h11);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule